// File: doc/BRIEF.md
# Predicated Condition-Gated Element Unit

This unit steps through a vector operation one element per clock. For each element it applies a two-operand integer operation to a pair of operands that it reads through an index port. From the signed result it derives a four-bit condition field. A per-element predicate mask, a zeroing switch, a condition-store switch, a compare-only switch and a three-bit test selector then decide what is written. The outputs are a result write port and a condition-field write port, both addressed by element number.

The test works like a conditional branch, but it is applied per element. One bit of the element's own freshly computed condition field is picked and compared with an expected value, and the result is committed only when they match. The condition field can be stored even when the result is cancelled, so later code can find out which elements failed. In compare-only mode every operation behaves like a compare: only condition fields are written.

A run starts with a one-cycle `start` while the unit is idle. At that moment the unit latches the length and all mode inputs. It raises `done` for one cycle together with the write of the last element.

Top module: `pcr_unit`

## Requirements
- R1: A `start` seen while idle latches the configuration and processes elements 0 to VL-1 in ascending order, one per cycle. `rd_idx` shows the element whose operands are read. That element's writes appear one cycle later with `wr_idx` equal to its number. A `vl` larger than MAXVL is treated as MAXVL.
- R2: The condition field is {lt, gt, eq, spare} in bits [3:0], taken from the signed result. lt means negative, gt means positive and non-zero, eq means zero, and the spare bit is always 0. Exactly one of lt, gt and eq is set.
- R3: The condition field of an active element (predicate bit set) is written when `rc` or `rc1` is 1, and is not written otherwise.
- R4: An element whose predicate bit is 0 never writes a condition field. It writes a result only when zeroing is on, and that result is 0.
- R5: `bo[2:1]` selects the tested bit (00 lt, 01 gt, 10 eq, 11 spare). An active element commits its result when the selected bit equals `bo[0]`.
- R6: An active element that fails the test writes a zero result when `zero_en` is 1, and writes no result when `zero_en` is 0.
- R7: With `rc1` set, no result is ever written, whatever the mask, the test or zeroing.
- R8: `op` selects 00 add, 01 subtract (a-b), 10 bitwise AND or 11 bitwise XOR. Results wrap modulo 2^W.
- R9: `done` is high for exactly one cycle, together with the writes of element VL-1. With VL=0, `done` rises in the cycle after `start` and nothing is written.
- R10: While `rst_n` is low and after its release, `res_we`, `cr_we` and `done` are 0 until a run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle) |
| vl | input | $clog2(MAXVL+1) | Element count |
| pred | input | MAXVL | Predicate mask, bit i enables element i |
| zero_en | input | 1 | Write zero for masked or failed elements |
| rc | input | 1 | Store condition fields |
| rc1 | input | 1 | Compare-only mode |
| bo | input | 3 | Test selector and expected bit |
| op | input | 2 | Operation select |
| rd_idx | output | IW | Element whose operands are read |
| opa | input | W | First operand of element `rd_idx` |
| opb | input | W | Second operand of element `rd_idx` |
| res_we | output | 1 | Result write enable |
| cr_we | output | 1 | Condition-field write enable |
| wr_idx | output | IW | Element number of the writes |
| res_data | output | W | Result write data |
| cr_data | output | 4 | Condition-field write data |
| done | output | 1 | Last element written / run finished |

## Verification
The hardest situation to reach is a single element in which the condition field is stored, the test fails and zeroing turns the cancelled result into a zero write, while a masked neighbour writes a zero result but no condition field. The stimulus places zero, negative and positive results side by side under sparse masks, so every outcome of the test occurs within one run. It also uses the spare bit, whose value is fixed, to force all elements to pass or all to fail. Separate runs cover compare-only mode with zeroing on, a zero length and a length above the maximum.

// File: rtl/pcr_pkg.sv
// Shared types for the predicated condition-gated element unit.
// Assumes the condition field is packed lt,gt,eq,spare from MSB to LSB.
package pcr_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } pcr_op_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic spare;
    } pcr_cond_t;
endpackage

// File: rtl/pcr_alu.sv
// Element datapath: computes one W-bit result and its condition field.
// Assumes two's complement operands; results wrap modulo 2^W.
module pcr_alu
    import pcr_pkg::*;
#(
    parameter int W = 16
) (
    input  pcr_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output pcr_cond_t    cond
);
    // Operation select.
    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            default: res = a ^ b;
        endcase
    end

    // Condition field derived from the signed result.
    always_comb begin
        cond.eq    = (res == '0);
        cond.lt    = res[W-1];
        cond.gt    = !res[W-1] && (res != '0);
        cond.spare = 1'b0;
    end
endmodule

// File: rtl/pcr_gate.sv
// Write-decision logic for one element: predicate, test and mode gating.
// Assumes cond is the element's own fresh field; purely combinational.
module pcr_gate
    import pcr_pkg::*;
(
    input  logic      active,
    input  pcr_cond_t cond,
    input  logic      zero_en,
    input  logic      rc,
    input  logic      rc1,
    input  logic [2:0] bo,
    output logic      res_we,
    output logic      res_zero,
    output logic      cr_we
);
    logic sel_bit;
    logic pass;

    // Pick the tested bit of the condition field.
    always_comb begin
        unique case (bo[2:1])
            2'b00:   sel_bit = cond.lt;
            2'b01:   sel_bit = cond.gt;
            2'b10:   sel_bit = cond.eq;
            default: sel_bit = cond.spare;
        endcase
    end

    // Commit, zero or cancel decision.
    always_comb begin
        pass     = active && !rc1 && (sel_bit == bo[0]);
        cr_we    = active && (rc || rc1);
        res_we   = !rc1 && (pass || zero_en);
        res_zero = !pass;
    end
endmodule

// File: rtl/pcr_seq.sv
// Element sequencer: accepts a start when idle and walks elements 0..len-1.
// Assumes vl above MAXVL is clamped; a zero length finishes at once.
module pcr_seq #(
    parameter int MAXVL = 8,
    parameter int IW    = 3,
    parameter int VLW   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl,
    output logic           busy,
    output logic [IW-1:0]  idx,
    output logic           last,
    output logic           accept,
    output logic           empty
);
    logic [VLW-1:0] vl_eff;
    logic [VLW-1:0] len_q;
    logic [IW-1:0]  cnt_q;

    // Clamp the requested length and classify the start.
    always_comb begin
        vl_eff = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;
        accept = !busy && start;
        empty  = accept && (vl_eff == '0);
        last   = busy && (VLW'(cnt_q) == len_q - VLW'(1));
        idx    = cnt_q;
    end

    // Run state and element counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            len_q <= '0;
        end else if (accept) begin
            busy  <= (vl_eff != '0);
            cnt_q <= '0;
            len_q <= vl_eff;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q + IW'(1);
            end
        end
    end
endmodule

// File: rtl/pcr_unit.sv
// Top: predicated, condition-gated element unit with registered write ports.
// Assumes operands arrive combinationally for rd_idx in the same cycle.
module pcr_unit
    import pcr_pkg::*;
#(
    parameter int W     = 16,
    parameter int MAXVL = 8,
    localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1,
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl,
    input  logic [MAXVL-1:0] pred,
    input  logic             zero_en,
    input  logic             rc,
    input  logic             rc1,
    input  logic [2:0]       bo,
    input  logic [1:0]       op,
    output logic [IW-1:0]    rd_idx,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output logic             res_we,
    output logic             cr_we,
    output logic [IW-1:0]    wr_idx,
    output logic [W-1:0]     res_data,
    output logic [3:0]       cr_data,
    output logic             done
);
    logic             busy, last, accept, empty;
    logic [IW-1:0]    idx;
    logic [MAXVL-1:0] mask_q;
    logic             zero_q, rc_q, rc1_q;
    logic [2:0]       bo_q;
    pcr_op_e          op_q;
    logic [W-1:0]     res;
    pcr_cond_t        cond;
    logic             g_res_we, g_res_zero, g_cr_we;
    logic             o_vld;

    pcr_seq #(.MAXVL(MAXVL), .IW(IW), .VLW(VLW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .busy(busy), .idx(idx), .last(last), .accept(accept), .empty(empty)
    );

    pcr_alu #(.W(W)) u_alu (
        .op(op_q), .a(opa), .b(opb), .res(res), .cond(cond)
    );

    pcr_gate u_gate (
        .active(mask_q[idx]), .cond(cond), .zero_en(zero_q), .rc(rc_q),
        .rc1(rc1_q), .bo(bo_q), .res_we(g_res_we), .res_zero(g_res_zero),
        .cr_we(g_cr_we)
    );

    assign rd_idx = idx;

    // Latch the run configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            zero_q <= 1'b0;
            rc_q   <= 1'b0;
            rc1_q  <= 1'b0;
            bo_q   <= '0;
            op_q   <= OP_ADD;
        end else if (accept) begin
            mask_q <= pred;
            zero_q <= zero_en;
            rc_q   <= rc;
            rc1_q  <= rc1;
            bo_q   <= bo;
            op_q   <= pcr_op_e'(op);
        end
    end

    // Register the write ports and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld    <= 1'b0;
            res_we   <= 1'b0;
            cr_we    <= 1'b0;
            wr_idx   <= '0;
            res_data <= '0;
            cr_data  <= '0;
            done     <= 1'b0;
        end else begin
            o_vld    <= busy;
            res_we   <= busy && g_res_we;
            cr_we    <= busy && g_cr_we;
            wr_idx   <= idx;
            res_data <= g_res_zero ? '0 : res;
            cr_data  <= cond;
            done     <= last || empty;
        end
    end
endmodule

// File: rtl/pcr_unit_chk.sv
// Checker for pcr_unit: temporal properties over ports and latched state.
// Assumes it is attached with the bind below.
module pcr_unit_chk #(
    parameter int W     = 16,
    parameter int MAXVL = 8,
    parameter int IW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_we,
    input logic             cr_we,
    input logic [IW-1:0]    wr_idx,
    input logic [W-1:0]     res_data,
    input logic [3:0]       cr_data,
    input logic             done,
    input logic             busy,
    input logic             o_vld,
    input logic [MAXVL-1:0] mask_q,
    input logic             rc_q,
    input logic             rc1_q
);
    a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && $past(o_vld)) |-> (wr_idx == $past(wr_idx) + IW'(1)));

    a_r2_field_shape: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (($countones(cr_data[3:1]) == 1) && !cr_data[0]));

    a_r2_sign_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && res_we && (res_data != '0)) |-> (res_data[W-1] == cr_data[3]));

    a_r3_store_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (rc_q || rc1_q));

    a_r4_masked_no_field: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> mask_q[wr_idx]);

    a_r7_compare_only: assert property (@(posedge clk) disable iff (!rst_n)
        rc1_q |-> !res_we);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pcr_unit pcr_unit_chk #(.W(W), .MAXVL(MAXVL), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_we(res_we), .cr_we(cr_we),
    .wr_idx(wr_idx), .res_data(res_data), .cr_data(cr_data), .done(done),
    .busy(busy), .o_vld(o_vld), .mask_q(mask_q), .rc_q(rc_q), .rc1_q(rc1_q)
);

// File: tb/pcr_unit_bench.sv
// Bench: behavioural per-element reference, compared on every output cycle.
module pcr_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int MAXVL = 8;
    localparam int IW = 3;
    localparam int VLW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VLW-1:0] vl = '0;
    logic [MAXVL-1:0] pred = '0;
    logic zero_en = 1'b0, rc = 1'b0, rc1 = 1'b0;
    logic [2:0] bo = '0;
    logic [1:0] op = '0;
    logic [IW-1:0] rd_idx, wr_idx;
    logic [W-1:0] opa, opb, res_data;
    logic res_we, cr_we, done;
    logic [3:0] cr_data;
    logic [W-1:0] va [MAXVL];
    logic [W-1:0] vb [MAXVL];
    int n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign opa = va[rd_idx];
    assign opb = vb[rd_idx];

    pcr_unit #(.W(W), .MAXVL(MAXVL)) u_pcr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred(pred),
        .zero_en(zero_en), .rc(rc), .rc1(rc1), .bo(bo), .op(op),
        .rd_idx(rd_idx), .opa(opa), .opb(opb), .res_we(res_we), .cr_we(cr_we),
        .wr_idx(wr_idx), .res_data(res_data), .cr_data(cr_data), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load(input int seed);
        for (int i = 0; i < MAXVL; i++) begin
            va[i] = W'(seed * (i + 3) - 40 * i);
            vb[i] = W'(seed + 7 * i * i - 25);
        end
    endtask

    task automatic run(input int req_vl, input logic [7:0] m, input logic z,
                       input logic c, input logic c1, input logic [2:0] b,
                       input logic [1:0] o);
        int n;
        n = (req_vl > MAXVL) ? MAXVL : req_vl;
        @(negedge clk);
        vl = VLW'(req_vl); pred = m; zero_en = z; rc = c; rc1 = c1; bo = b; op = o;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done && !res_we && !cr_we, "R9 empty run", {done, res_we, cr_we}, 3'b100);
        end
        for (int e = 0; e < n; e++) begin
            logic [W-1:0] r;
            logic [3:0] fld;
            logic sel, pass, act, ex_rwe, ex_cwe;
            @(negedge clk);
            case (o)
                2'b00: r = va[e] + vb[e];
                2'b01: r = va[e] - vb[e];
                2'b10: r = va[e] & vb[e];
                default: r = va[e] ^ vb[e];
            endcase
            fld = {r[W-1], !r[W-1] && (r != 0), r == 0, 1'b0};
            sel = fld[3 - b[2:1]];
            act = m[e];
            pass = act && !c1 && (sel == b[0]);
            ex_cwe = act && (c || c1);
            ex_rwe = !c1 && (pass || z);
            chk(wr_idx == IW'(e), "R1 index", int'(wr_idx), e);
            chk(cr_we == ex_cwe, act ? "R3 field store" : "R4 masked field", cr_we, ex_cwe);
            chk(res_we == ex_rwe, c1 ? "R7 compare only" : (!act ? "R4 masked result" : "R5/R6 result gate"),
                res_we, ex_rwe);
            if (res_we && ex_rwe)
                chk(res_data == (pass ? r : '0), pass ? "R8 result value" : "R6 zero write",
                    int'(res_data), int'(pass ? r : '0));
            if (cr_we && ex_cwe)
                chk(cr_data == fld, "R2 field value", cr_data, fld);
            chk(done == (e == n - 1), "R9 done timing", done, e == n - 1);
        end
        @(negedge clk);
        chk(!done && !res_we && !cr_we, "R9 single pulse", {done, res_we, cr_we}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        load(11);
        repeat (3) @(negedge clk);
        chk(!res_we && !cr_we && !done, "R10 reset", {res_we, cr_we, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!res_we && !cr_we && !done, "R10 after reset", {res_we, cr_we, done}, 0);
        // R5: gt==1 test, full mask, fields stored
        run(8, 8'hFF, 1'b0, 1'b1, 1'b0, 3'b011, 2'b00);
        // R6: eq==0 test, sparse mask, zeroing
        load(5); va[2] = 16'd9; vb[2] = 16'd9;
        run(8, 8'b1011_0101, 1'b1, 1'b0, 1'b0, 3'b100, 2'b01);
        // R7: compare-only with zeroing and mask
        run(8, 8'h5A, 1'b1, 1'b0, 1'b1, 3'b001, 2'b10);
        // R5: spare bit expected 0 -> every active element commits
        load(-13);
        run(5, 8'hFF, 1'b0, 1'b1, 1'b0, 3'b110, 2'b11);
        // R6: spare bit expected 1 -> every active element fails, zeroed
        run(6, 8'hF3, 1'b1, 1'b1, 1'b0, 3'b111, 2'b00);
        // R9: zero length
        run(0, 8'hFF, 1'b1, 1'b1, 1'b0, 3'b011, 2'b00);
        // R1/R8: length above maximum, wrap-around add
        va[0] = 16'h7FFF; vb[0] = 16'h0001; va[1] = 16'h8000; vb[1] = 16'hFFFF;
        run(12, 8'hFF, 1'b0, 1'b1, 1'b0, 3'b001, 2'b00);
        // R4: lt==1 test, no zeroing, no field store
        load(23); va[3] = 16'hFFF0; vb[3] = 16'h0001;
        run(7, 8'b0110_1001, 1'b0, 1'b0, 1'b0, 3'b001, 2'b01);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule